// File: doc/BRIEF.md
# Pipeline Hazard Stall Unit

This block is the hazard controller for a five-stage in-order pipeline whose branches are compared and resolved in the decode stage. It watches three things: the source register indices of the instruction now in decode, the instruction one stage ahead (between decode and execute), and the instruction two stages ahead (between execute and memory). From these it works out when forwarding alone cannot supply an operand in time. When that happens it holds the program counter and the fetch/decode register, and it replaces the control word entering execute with a no-op bubble.

The block covers two cases. The first is the classic load-use dependency, which costs one cycle. The second is a decode-stage branch that compares a register still being produced. That costs one cycle when the producer is an ALU operation directly ahead, or a load two instructions ahead. It costs two cycles when the producer is a load directly ahead. When a branch is taken and is allowed to leave decode, the block also flushes the one instruction fetched behind it. All outputs are combinational functions of the current stage contents, so the block drops into the same cycle as the stage registers it steers.

Top module: `hazard_stall_unit`

## Requirements
- R1: When the instruction ahead of decode reads memory and its destination index is nonzero and equals the decode instruction's rs or rt, the block drives pc_we=0, ifid_we=0 and idex_bubble=1 in that same cycle.
- R2: With no hazard present, the block drives pc_we=1, ifid_we=1, idex_bubble=0, and drives ifid_flush=0 unless a branch is taken.
- R3: A destination index of 0 in either stage ahead never causes a stall, whatever the flags are.
- R4: A branch in decode stalls when the instruction directly ahead writes a register (ALU result or load) whose nonzero index equals the branch's rs or rt.
- R5: A branch in decode stalls when the instruction two ahead is a load that writes a nonzero register matching rs or rt. An ALU result two ahead does not stall a branch.
- R6: A non-branch instruction is not stalled by a load two ahead, nor by an ALU result directly ahead. Both of these are left to forwarding.
- R7: When a branch in decode has branch_taken=1 and no stall is raised, ifid_flush=1 for that cycle. A branch that is not taken gives ifid_flush=0.
- R8: A stall takes priority over a flush: ifid_flush is 0 in every cycle where idex_bubble is 1.
- R9: A branch that compares the destination of the load directly ahead of it sees exactly two consecutive stall cycles. It then leaves decode in the third cycle, and the flush, if any, is raised in that third cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | REG_W | First source register index of the decode instruction |
| id_rt | input | REG_W | Second source register index of the decode instruction |
| id_is_branch | input | 1 | Decode instruction is a compare-and-branch |
| id_branch_taken | input | 1 | Decode-stage comparator outcome |
| ex_mem_read | input | 1 | Instruction ahead of decode is a load |
| ex_reg_write | input | 1 | Instruction ahead of decode writes a register |
| ex_rd | input | REG_W | Destination index of the instruction ahead of decode |
| mem_mem_read | input | 1 | Instruction two ahead is a load |
| mem_reg_write | input | 1 | Instruction two ahead writes a register |
| mem_rd | input | REG_W | Destination index of the instruction two ahead |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Fetch/decode register update enable |
| idex_bubble | output | 1 | Force control word entering execute to zero |
| ifid_flush | output | 1 | Replace fetch/decode entry with an all-zero word |

## Verification
The bench builds the block with REG_W=5. That gives 32 register indices, including the hardwired zero, so it can drive matches on rs only, on rt only, on both, and on index 0. The bench runs a small program through a behavioural three-slot pipeline model that inserts its own bubbles and flushes. Because of that, the two-cycle branch-after-load case and the single-cycle cases appear as real stall sequences and are counted per scenario, rather than checked as isolated input vectors.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic idex_bubble;
        logic ifid_flush;
    } hz_ctrl_t;

    localparam int NUM_SRC = 2;

endpackage

// File: rtl/hz_load_use.sv
module hz_load_use #(
    parameter int REG_W = 5
) (
    input  logic             ex_mem_read,
    input  logic [REG_W-1:0] ex_rd,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    output logic             load_use_d
);

    logic rd_live;

    always_comb begin
        rd_live    = |ex_rd;
        load_use_d = ex_mem_read && rd_live &&
                     ((ex_rd == id_rs) || (ex_rd == id_rt));
    end

endmodule

// File: rtl/hz_branch_dep.sv
module hz_branch_dep
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             id_is_branch,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             ex_reg_write,
    input  logic             ex_mem_read,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             mem_mem_read,
    input  logic             mem_reg_write,
    input  logic [REG_W-1:0] mem_rd,
    output logic             br_hold_d
);

    logic [NUM_SRC-1:0][REG_W-1:0] srcs;
    logic [NUM_SRC-1:0]            near_hit;
    logic [NUM_SRC-1:0]            far_hit;
    logic                          near_prod;
    logic                          far_prod;

    assign srcs      = {id_rt, id_rs};
    assign near_prod = (ex_reg_write || ex_mem_read) && (|ex_rd);
    assign far_prod  = mem_mem_read && mem_reg_write && (|mem_rd);

    // one comparator pair per compared operand
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        always_comb begin
            near_hit[i] = near_prod && (ex_rd  == srcs[i]);
            far_hit[i]  = far_prod  && (mem_rd == srcs[i]);
        end
    end

    always_comb begin
        br_hold_d = id_is_branch && ((|near_hit) || (|far_hit));
    end

endmodule

// File: rtl/hz_ctrl_merge.sv
module hz_ctrl_merge
    import hz_pkg::*;
(
    input  logic     load_use_d,
    input  logic     br_hold_d,
    input  logic     id_is_branch,
    input  logic     id_branch_taken,
    output hz_ctrl_t ctrl_d
);

    logic hold;

    always_comb begin
        hold               = load_use_d || br_hold_d;
        ctrl_d.pc_we       = !hold;
        ctrl_d.ifid_we     = !hold;
        ctrl_d.idex_bubble = hold;
        // the branch may only redirect once it actually leaves decode
        ctrl_d.ifid_flush  = !hold && id_is_branch && id_branch_taken;
    end

endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_is_branch,
    input  logic             id_branch_taken,
    input  logic             ex_mem_read,
    input  logic             ex_reg_write,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             mem_mem_read,
    input  logic             mem_reg_write,
    input  logic [REG_W-1:0] mem_rd,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             idex_bubble,
    output logic             ifid_flush
);

    logic     load_use_d;
    logic     br_hold_d;
    hz_ctrl_t ctrl_d;

    hz_load_use #(.REG_W(REG_W)) u_load_use (
        .ex_mem_read (ex_mem_read),
        .ex_rd       (ex_rd),
        .id_rs       (id_rs),
        .id_rt       (id_rt),
        .load_use_d  (load_use_d)
    );

    hz_branch_dep #(.REG_W(REG_W)) u_branch_dep (
        .id_is_branch  (id_is_branch),
        .id_rs         (id_rs),
        .id_rt         (id_rt),
        .ex_reg_write  (ex_reg_write),
        .ex_mem_read   (ex_mem_read),
        .ex_rd         (ex_rd),
        .mem_mem_read  (mem_mem_read),
        .mem_reg_write (mem_reg_write),
        .mem_rd        (mem_rd),
        .br_hold_d     (br_hold_d)
    );

    hz_ctrl_merge u_merge (
        .load_use_d      (load_use_d),
        .br_hold_d       (br_hold_d),
        .id_is_branch    (id_is_branch),
        .id_branch_taken (id_branch_taken),
        .ctrl_d          (ctrl_d)
    );

    assign pc_we       = ctrl_d.pc_we;
    assign ifid_we     = ctrl_d.ifid_we;
    assign idex_bubble = ctrl_d.idex_bubble;
    assign ifid_flush  = ctrl_d.ifid_flush;

endmodule

// File: rtl/hazard_stall_unit_chk.sv
module hazard_stall_unit_chk #(
    parameter int REG_W = 5
) (
    input logic [REG_W-1:0] id_rs,
    input logic [REG_W-1:0] id_rt,
    input logic             id_is_branch,
    input logic             id_branch_taken,
    input logic             ex_mem_read,
    input logic             ex_reg_write,
    input logic [REG_W-1:0] ex_rd,
    input logic             mem_mem_read,
    input logic             mem_reg_write,
    input logic [REG_W-1:0] mem_rd,
    input logic             pc_we,
    input logic             ifid_we,
    input logic             idex_bubble,
    input logic             ifid_flush
);

    always_comb begin
        if (ex_mem_read && (ex_rd != '0) && ((ex_rd == id_rs) || (ex_rd == id_rt))) begin
            assert_loaduse_hold_R1: assert (!pc_we && !ifid_we && idex_bubble)
                else $error("load-use dependency did not hold the front end");
        end
        assert_front_end_agree_R2: assert ((pc_we == ifid_we) && (idex_bubble == !pc_we))
            else $error("pc/ifid enables and bubble disagree");
        if ((ex_rd == '0) && (mem_rd == '0)) begin
            assert_zero_dest_free_R3: assert (pc_we)
                else $error("stall raised with only zero destinations ahead");
        end
        if (!id_is_branch) begin
            assert_nonbranch_no_flush_R7: assert (!ifid_flush)
                else $error("flush without a branch in decode");
        end
        if (id_is_branch && !id_branch_taken) begin
            assert_not_taken_no_flush_R7: assert (!ifid_flush)
                else $error("flush on a not-taken branch");
        end
        assert_stall_over_flush_R8: assert (!(ifid_flush && idex_bubble))
            else $error("flush raised while stalling");
        if (id_is_branch && (ex_rd != '0) && (ex_reg_write || ex_mem_read) &&
            ((ex_rd == id_rs) || (ex_rd == id_rt))) begin
            assert_branch_near_dep_R4: assert (idex_bubble)
                else $error("branch left decode with its operand one stage ahead");
        end
        if (id_is_branch && mem_mem_read && mem_reg_write && (mem_rd != '0) &&
            ((mem_rd == id_rs) || (mem_rd == id_rt))) begin
            assert_branch_far_load_R5: assert (idex_bubble)
                else $error("branch left decode with a load result two ahead");
        end
    end

endmodule

bind hazard_stall_unit hazard_stall_unit_chk #(.REG_W(REG_W)) u_chk (
    .id_rs           (id_rs),
    .id_rt           (id_rt),
    .id_is_branch    (id_is_branch),
    .id_branch_taken (id_branch_taken),
    .ex_mem_read     (ex_mem_read),
    .ex_reg_write    (ex_reg_write),
    .ex_rd           (ex_rd),
    .mem_mem_read    (mem_mem_read),
    .mem_reg_write   (mem_reg_write),
    .mem_rd          (mem_rd),
    .pc_we           (pc_we),
    .ifid_we         (ifid_we),
    .idex_bubble     (idex_bubble),
    .ifid_flush      (ifid_flush)
);

// File: tb/sim_hazard_stall_unit.sv
module sim_hazard_stall_unit;

    localparam int CLK_PERIOD = 10;
    localparam int RW         = 5;
    localparam int NSEG       = 8;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [RW-1:0] id_rs = '0, id_rt = '0, ex_rd = '0, mem_rd = '0;
    logic id_is_branch = 1'b0, id_branch_taken = 1'b0;
    logic ex_mem_read = 1'b0, ex_reg_write = 1'b0;
    logic mem_mem_read = 1'b0, mem_reg_write = 1'b0;
    logic pc_we, ifid_we, idex_bubble, ifid_flush;

    hazard_stall_unit #(.REG_W(RW)) u0 (
        .id_rs(id_rs), .id_rt(id_rt), .id_is_branch(id_is_branch),
        .id_branch_taken(id_branch_taken), .ex_mem_read(ex_mem_read),
        .ex_reg_write(ex_reg_write), .ex_rd(ex_rd), .mem_mem_read(mem_mem_read),
        .mem_reg_write(mem_reg_write), .mem_rd(mem_rd), .pc_we(pc_we),
        .ifid_we(ifid_we), .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
    );

    typedef struct {
        bit ld; bit wr; int rd; int rs; int rt; bit br; bit tk; int seg;
    } ins_t;

    ins_t  prog[$];
    ins_t  ifid, idex, exmem;
    int    pc;
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    int    stalls[NSEG];
    int    flushes[NSEG];
    string tag[NSEG]   = '{"R2", "R1", "R3", "R4", "R5", "R6", "R7", "R8"};
    int    exp_st[NSEG] = '{0, 2, 0, 1, 1, 0, 0, 2};
    int    exp_fl[NSEG] = '{0, 0, 0, 0, 0, 0, 1, 1};

    function automatic ins_t mk(bit ld, bit wr, int rd, int rs, int rt, bit br, bit tk, int seg);
        ins_t x;
        x.ld = ld; x.wr = wr; x.rd = rd; x.rs = rs; x.rt = rt;
        x.br = br; x.tk = tk; x.seg = seg;
        return x;
    endfunction

    function automatic ins_t nop();
        return mk(0, 0, 0, 0, 0, 0, 0, 0);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive();
        id_rs           = ifid.rs[RW-1:0];
        id_rt           = ifid.rt[RW-1:0];
        id_is_branch    = ifid.br;
        id_branch_taken = ifid.tk;
        ex_mem_read     = idex.ld;
        ex_reg_write    = idex.wr;
        ex_rd           = idex.rd[RW-1:0];
        mem_mem_read    = exmem.ld;
        mem_reg_write   = exmem.wr;
        mem_rd          = exmem.rd[RW-1:0];
    endtask

    // behavioural decision: would decode have to wait this cycle?
    function automatic bit must_wait(ins_t d, ins_t e, ins_t m);
        int  ops[2];
        bit  w = 0;
        ops[0] = d.rs;
        ops[1] = d.rt;
        foreach (ops[k]) begin
            if (ops[k] != 0) begin
                if (e.ld && e.rd == ops[k]) w = 1;
                if (d.br && e.wr && e.rd == ops[k]) w = 1;
                if (d.br && m.ld && m.wr && m.rd == ops[k]) w = 1;
            end
        end
        return w;
    endfunction

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // seg0: independent ALU ops
        prog.push_back(mk(0, 1, 1, 2, 3, 0, 0, 0));
        prog.push_back(mk(0, 1, 4, 5, 6, 0, 0, 0));
        // seg1: load-use on rs, then on rt
        prog.push_back(mk(1, 1, 5, 1, 0, 0, 0, 1));
        prog.push_back(mk(0, 1, 6, 5, 2, 0, 0, 1));
        prog.push_back(mk(1, 1, 7, 1, 0, 0, 0, 1));
        prog.push_back(mk(0, 1, 8, 3, 7, 0, 0, 1));
        // seg2: load to register 0 then use of register 0
        prog.push_back(mk(1, 1, 0, 0, 0, 0, 0, 2));
        prog.push_back(mk(0, 1, 9, 0, 0, 0, 0, 2));
        // seg3: ALU result directly ahead of a branch
        prog.push_back(mk(0, 1, 7, 1, 2, 0, 0, 3));
        prog.push_back(mk(0, 0, 0, 7, 3, 1, 0, 3));
        // seg4: load two ahead of a branch; ALU two ahead of a branch
        prog.push_back(mk(1, 1, 8, 0, 0, 0, 0, 4));
        prog.push_back(mk(0, 1, 9, 1, 1, 0, 0, 4));
        prog.push_back(mk(0, 0, 0, 2, 8, 1, 0, 4));
        prog.push_back(mk(0, 1, 10, 1, 2, 0, 0, 4));
        prog.push_back(mk(0, 1, 11, 1, 2, 0, 0, 4));
        prog.push_back(mk(0, 0, 0, 10, 0, 1, 0, 4));
        // seg5: forwarding-covered cases for non-branches
        prog.push_back(mk(1, 1, 11, 0, 0, 0, 0, 5));
        prog.push_back(mk(0, 1, 12, 1, 2, 0, 0, 5));
        prog.push_back(mk(0, 1, 13, 11, 11, 0, 0, 5));
        prog.push_back(mk(0, 1, 14, 1, 2, 0, 0, 5));
        prog.push_back(mk(0, 1, 15, 14, 14, 0, 0, 5));
        // seg6: taken branch with no dependency
        prog.push_back(mk(0, 0, 0, 1, 2, 1, 1, 6));
        prog.push_back(mk(0, 1, 3, 1, 1, 0, 0, 6));
        // seg7: taken branch on the load directly ahead
        prog.push_back(mk(1, 1, 12, 0, 0, 0, 0, 7));
        prog.push_back(mk(0, 0, 0, 12, 0, 1, 1, 7));

        foreach (stalls[s]) begin
            stalls[s]  = 0;
            flushes[s] = 0;
        end
        ifid = nop(); idex = nop(); exmem = nop(); pc = 0;
        drive();

        // idle state: empty pipeline must run freely
        @(negedge clk);
        chk(pc_we == 1'b1,       "R2", "idle pc_we",       int'(pc_we),       1);
        chk(ifid_we == 1'b1,     "R2", "idle ifid_we",     int'(ifid_we),     1);
        chk(idex_bubble == 1'b0, "R2", "idle idex_bubble", int'(idex_bubble), 0);
        chk(ifid_flush == 1'b0,  "R2", "idle ifid_flush",  int'(ifid_flush),  0);

        for (int cyc = 0; cyc < prog.size() + 12; cyc++) begin
            bit    w;
            bit    fl;
            string rq;
            ins_t  f;
            @(negedge clk);
            w  = must_wait(ifid, idex, exmem);
            fl = !w && ifid.br && ifid.tk;
            rq = tag[ifid.seg];
            chk(pc_we == !w,       rq, "pc_we",       int'(pc_we),       int'(!w));
            chk(ifid_we == !w,     rq, "ifid_we",     int'(ifid_we),     int'(!w));
            chk(idex_bubble == w,  rq, "idex_bubble", int'(idex_bubble), int'(w));
            chk(ifid_flush == fl,  rq, "ifid_flush",  int'(ifid_flush),  int'(fl));
            if (w) stalls[ifid.seg]++;
            if (fl) flushes[ifid.seg]++;
            // advance the model pipeline
            exmem = idex;
            if (w) begin
                idex = nop();
            end else begin
                idex = ifid;
                f = (pc < prog.size()) ? prog[pc] : nop();
                if (fl) begin
                    ifid = nop();
                end else begin
                    ifid = f;
                    pc++;
                end
            end
            drive();
        end

        for (int s = 0; s < NSEG; s++) begin
            chk(stalls[s] == exp_st[s], (s == 7) ? "R9" : tag[s],
                $sformatf("stall cycles in scenario %0d", s), stalls[s], exp_st[s]);
            chk(flushes[s] == exp_fl[s], (s == 7) ? "R9" : tag[s],
                $sformatf("flush cycles in scenario %0d", s), flushes[s], exp_fl[s]);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule